// File: doc/BRIEF.md
# Two-Channel Offset Calibration Controller

This block sits in the digital back end of a stereo delta-sigma converter, after decimation. It removes each channel's DC offset from the sample stream. When the synchronous reset is released, a calibration cycle starts on its own. During that cycle the block averages a fixed number of samples per channel and keeps the result as that channel's offset. From then on, every sample of that channel leaves the block with its stored offset subtracted. The result is clamped to the signed output range.

A source-select pin decides what is averaged during calibration. One choice is the live signal word; the other is a measurement word of the common-mode reference, which arrives on the same strobe. A single-cycle request starts a fresh calibration later on, for example once an external reference has settled. The status output `cal_busy` is high for exactly as long as a calibration runs. No output samples are produced while it is high.

Top module: `ofc_offset_cal`

## Requirements
- R1: While `rst` is high, `out_valid` and `cal_busy` are low one cycle later and stay low, whatever the sample inputs do.
- R2: On the first rising edge with `rst` low, calibration starts by itself. `cal_busy` is high from that edge on.
- R3: During calibration a valid sample counts for the left channel when `in_right` is 0 and for the right channel when it is 1. Only the first 2^AVG_LOG2 samples of each channel are accumulated, and any further samples of a full channel are ignored. `cal_busy` falls one edge after the edge that accepted the last sample needed to fill both channels.
- R4: The stored offset of a channel is the sum of its accumulated samples shifted right arithmetically by AVG_LOG2, which rounds toward minus infinity.
- R5: With `src_sel` high, the accumulated value is `in_data`. With `src_sel` low, it is `ref_data`.
- R6: Outside calibration, every valid input yields a one-cycle `out_valid` pulse on the next edge. That edge also sets `out_right` to the input's `in_right` and `out_data` to `in_data` minus that channel's stored offset.
- R7: The subtraction is done with one extra bit. A result above 2^23-1 is output as 2^23-1, and a result below -2^23 is output as -2^23.
- R8: `out_valid` stays low while calibration runs. The first valid input presented after `cal_busy` has fallen produces a corrected output.
- R9: A `cal_req` pulse while the block is idle sets `cal_busy` on the next edge and restarts both accumulations. The stored offsets change only at the end of that calibration.
- R10: A `cal_req` pulse during calibration is ignored. The running accumulation continues, and the cycle ends after the same number of samples as without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (digital section powered down) |
| cal_req | input | 1 | Single-cycle recalibration request |
| src_sel | input | 1 | Calibration source: 1 = signal word, 0 = reference word |
| in_valid | input | 1 | Input sample strobe |
| in_right | input | 1 | Channel of the input sample: 0 = left, 1 = right |
| in_data | input | DW (24) | Signed signal sample |
| ref_data | input | DW (24) | Signed common-mode reference measurement |
| cal_busy | output | 1 | High while calibration runs |
| out_valid | output | 1 | Corrected sample strobe |
| out_right | output | 1 | Channel of the corrected sample |
| out_data | output | DW (24) | Signed corrected, saturated sample |

## Verification
Two kinds of internal fault are visible at the ports. A miscounting accumulator moves the falling edge of `cal_busy` away from the exact edge after the last needed sample, so the fault shows during calibration itself. A wrong sum, shift or source mux shows only later, on the first corrected output of each channel, as a fixed error in `out_data`. The bench therefore times the end of calibration to the edge. It then checks corrected values that are chosen so that floor rounding, the source selection, discarded extra samples and both saturation limits each give a distinct expected value.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    // Sequencer states: held after reset, measuring, correcting
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_CAL  = 2'd1,
        ST_RUN  = 2'd2
    } cal_state_e;

    localparam int NUM_CH   = 2;
    localparam logic CH_LEFT  = 1'b0;
    localparam logic CH_RIGHT = 1'b1;

    // Tag carried alongside a corrected sample
    typedef struct packed {
        logic valid;
        logic right;
    } out_tag_t;

endpackage

// File: rtl/ofc_accum.sv
module ofc_accum #(
    parameter int DW       = 24,
    parameter int AVG_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 add,
    input  logic signed [DW-1:0] sample,
    input  logic                 load,
    output logic                 full,
    output logic signed [DW-1:0] offs
);
    localparam int AW = DW + AVG_LOG2;
    localparam int CW = AVG_LOG2 + 1;

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] avg;
    logic [CW-1:0]        cnt;

    assign full = cnt[AVG_LOG2];
    assign avg  = acc >>> AVG_LOG2;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (add && !full) begin
            acc <= acc + AW'(sample);
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offs <= '0;
        end else if (load) begin
            offs <= avg[DW-1:0];
        end
    end

    // R3: sample count only grows between clears
    assert_count_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

    // R9: stored offset is replaced only by a load at the end of calibration
    assert_offset_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(offs));

endmodule

// File: rtl/ofc_seq.sv
module ofc_seq
    import ofc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cal_req,
    input  logic both_full,
    output logic busy,
    output logic run,
    output logic clr,
    output logic load
);
    cal_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        case (state)
            ST_HOLD: state_nxt = ST_CAL;
            ST_CAL:  state_nxt = both_full ? ST_RUN : ST_CAL;
            ST_RUN:  state_nxt = cal_req ? ST_CAL : ST_RUN;
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= state_nxt;
    end

    assign busy = (state == ST_CAL);
    assign run  = (state == ST_RUN);
    assign clr  = (state == ST_HOLD) || (run && cal_req);
    assign load = busy && both_full;

    // R2: calibration begins on the first edge after reset release
    assert_start_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> busy);

    // R9: a request while idle restarts calibration on the next edge
    assert_restart_on_req_R9: assert property (@(posedge clk) disable iff (rst)
        (run && cal_req) |=> busy);

    // R10: a request during an unfinished calibration does not end or restart it
    assert_req_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cal_req && !both_full) |=> (busy && !clr));

endmodule

// File: rtl/ofc_corr.sv
module ofc_corr
    import ofc_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 in_valid,
    input  logic                 in_right,
    input  logic signed [DW-1:0] in_data,
    input  logic signed [DW-1:0] offs_l,
    input  logic signed [DW-1:0] offs_r,
    output logic                 out_valid,
    output logic                 out_right,
    output logic signed [DW-1:0] out_data
);
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] offs_sel;
    logic signed [DW:0]   diff;
    logic signed [DW-1:0] clamped;
    out_tag_t             tag_q;

    assign offs_sel = (in_right == CH_RIGHT) ? offs_r : offs_l;
    assign diff     = (DW+1)'(in_data) - (DW+1)'(offs_sel);

    always_comb begin
        if (diff[DW] != diff[DW-1]) clamped = diff[DW] ? SMIN : SMAX;
        else                        clamped = diff[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q    <= '0;
            out_data <= '0;
        end else begin
            tag_q.valid <= go && in_valid;
            tag_q.right <= in_right;
            if (go && in_valid) out_data <= clamped;
        end
    end

    assign out_valid = tag_q.valid;
    assign out_right = tag_q.right;

    // R6: each accepted input gives an output strobe on the next edge
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (go && in_valid) |=> out_valid);

    // R8: nothing leaves the block while correction is not enabled
    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !go |=> !out_valid);

    // R7: full-scale positive input minus a negative left offset clamps to the top
    assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
        (go && in_valid && !in_right && in_data == SMAX && offs_l < 0)
        |=> (out_data == SMAX));

endmodule

// File: rtl/ofc_offset_cal.sv
module ofc_offset_cal
    import ofc_pkg::*;
#(
    parameter int DW       = 24,
    parameter int AVG_LOG2 = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cal_req,
    input  logic                 src_sel,
    input  logic                 in_valid,
    input  logic                 in_right,
    input  logic signed [DW-1:0] in_data,
    input  logic signed [DW-1:0] ref_data,
    output logic                 cal_busy,
    output logic                 out_valid,
    output logic                 out_right,
    output logic signed [DW-1:0] out_data
);
    logic                 busy, run, clr, load, both_full;
    logic signed [DW-1:0] meas;
    logic [NUM_CH-1:0]    full;
    logic signed [DW-1:0] offs [NUM_CH];

    assign meas      = src_sel ? in_data : ref_data;
    assign both_full = &full;
    assign cal_busy  = busy;

    ofc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cal_req   (cal_req),
        .both_full (both_full),
        .busy      (busy),
        .run       (run),
        .clr       (clr),
        .load      (load)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ofc_accum #(
            .DW       (DW),
            .AVG_LOG2 (AVG_LOG2)
        ) u_accum (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .add    (busy && in_valid && (in_right == 1'(c))),
            .sample (meas),
            .load   (load),
            .full   (full[c]),
            .offs   (offs[c])
        );
    end

    ofc_corr #(
        .DW (DW)
    ) u_corr (
        .clk       (clk),
        .rst       (rst),
        .go        (run),
        .in_valid  (in_valid),
        .in_right  (in_right),
        .in_data   (in_data),
        .offs_l    (offs[0]),
        .offs_r    (offs[1]),
        .out_valid (out_valid),
        .out_right (out_right),
        .out_data  (out_data)
    );

    // R1: reset silences the outputs and the status flag
    assert_silent_in_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !cal_busy));

    // R8: no corrected sample appears while calibration is running
    assert_no_out_during_cal_R8: assert property (@(posedge clk) disable iff (rst)
        cal_busy |=> !out_valid);

endmodule

// File: tb/ofc_offset_cal_bench.sv
module ofc_offset_cal_bench;
    localparam int DW   = 24;
    localparam int NLOG = 4;
    localparam int NS   = 1 << NLOG;
    localparam longint SMAX = 8388607;
    localparam longint SMIN = -8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cal_req = 1'b0;
    logic src_sel = 1'b1;
    logic in_valid = 1'b0;
    logic in_right = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic signed [DW-1:0] ref_data = '0;
    logic cal_busy, out_valid, out_right;
    logic signed [DW-1:0] out_data;

    int n_checks = 0;
    int n_err = 0;
    longint exp_off [2];

    always #5 clk = ~clk;

    ofc_offset_cal #(.DW(DW), .AVG_LOG2(NLOG)) u_ofc_offset_cal (
        .clk(clk), .rst(rst), .cal_req(cal_req), .src_sel(src_sel),
        .in_valid(in_valid), .in_right(in_right), .in_data(in_data),
        .ref_data(ref_data), .cal_busy(cal_busy), .out_valid(out_valid),
        .out_right(out_right), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint clamp(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    // Present one sample for one cycle; returns at the negedge after its accept edge
    task automatic drive(input bit r, input longint d, input longint rv);
        @(negedge clk);
        in_valid = 1'b1;
        in_right = r;
        in_data  = DW'(d);
        ref_data = DW'(rv);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
    endtask

    task automatic test_reset_and_start();
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(1234 * i);
            in_right = i[0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        chk(cal_busy == 1'b0, "R1", "cal_busy in reset", longint'(cal_busy), 0);
        rst = 1'b0;
        chk(cal_busy == 1'b0, "R2", "cal_busy before first edge", longint'(cal_busy), 0);
        @(negedge clk);
        chk(cal_busy == 1'b1, "R2", "cal_busy after release", longint'(cal_busy), 1);
    endtask

    // Feed one full calibration: left channel then right channel
    task automatic cal_run(input bit sel, input longint lb, input longint ls,
                           input longint rb, input longint rs, input bit mid_req);
        longint sum [2];
        longint v;
        src_sel = sel;
        sum[0] = 0;
        sum[1] = 0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < NS; i++) begin
                v = (ch == 0) ? lb + ls * i : rb + rs * i;
                sum[ch] += v;
                if (sel) drive(ch[0], v, 3 - v);
                else     drive(ch[0], 7777777, v);
                chk(out_valid == 1'b0, "R8", "out_valid during cal", longint'(out_valid), 0);
                if (mid_req && ch == 0 && i == 5) begin
                    pulse_req();
                    chk(cal_busy == 1'b1, "R10", "busy after ignored req", longint'(cal_busy), 1);
                end
                if (!(ch == 1 && i == NS - 1))
                    chk(cal_busy == 1'b1, "R3", "busy before both full", longint'(cal_busy), 1);
            end
            if (ch == 0) begin
                // extra left samples after the left channel is full must not count
                for (int k = 0; k < 3; k++) begin
                    drive(1'b0, 8000000, 8000000);
                    chk(out_valid == 1'b0, "R3", "out_valid on extra sample", longint'(out_valid), 0);
                end
            end
        end
        chk(cal_busy == 1'b1, "R3", "busy on edge of last accept", longint'(cal_busy), 1);
        @(negedge clk);
        chk(cal_busy == 1'b0, "R3", "busy after completion", longint'(cal_busy), 0);
        exp_off[0] = sum[0] >>> NLOG;
        exp_off[1] = sum[1] >>> NLOG;
    endtask

    task automatic corr(input bit r, input longint d, input string req);
        longint e;
        e = clamp(d - exp_off[r]);
        drive(r, d, 0);
        chk(out_valid == 1'b1, "R6", "out_valid", longint'(out_valid), 1);
        chk(out_right == r, "R6", "out_right", longint'(out_right), longint'(r));
        chk(longint'(out_data) == e, req, "out_data", longint'(out_data), e);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", "out_valid pulse width", longint'(out_valid), 0);
    endtask

    task automatic test_signal_cal();
        // left sum -11560 -> floor(-722.5) = -723 ; right sum 32360 -> 2022
        cal_run(1'b1, -1000, 37, 2000, 3, 1'b0);
        chk(exp_off[0] == -723, "R4", "bench left offset", exp_off[0], -723);
        corr(1'b0, 100, "R8");
        corr(1'b1, -5, "R4");
        corr(1'b0, -8388608, "R6");
        corr(1'b1, 0, "R5");
    endtask

    task automatic test_recal_reference();
        pulse_req();
        chk(cal_busy == 1'b1, "R9", "busy after idle req", longint'(cal_busy), 1);
        cal_run(1'b0, 4194304, 0, -4194304, 0, 1'b1);
        corr(1'b0, 4194303, "R5");
        corr(1'b1, -4194304, "R9");
        corr(1'b0, -8388608, "R7");
        corr(1'b1, 8388607, "R7");
    endtask

    task automatic test_reset_midrun();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 5000, 0);
        chk(out_valid == 1'b0, "R1", "out_valid after mid-run reset", longint'(out_valid), 0);
        chk(cal_busy == 1'b0, "R1", "cal_busy after mid-run reset", longint'(cal_busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cal_busy == 1'b1, "R2", "restart after second release", longint'(cal_busy), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        test_reset_and_start();
        test_signal_cal();
        test_recal_reference();
        test_reset_midrun();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule